// File: doc/BRIEF.md
# Bus Fault Capture Register

This block keeps a 16-bit sticky record of faults reported by the memory system and by two free-running system fault lines. It watches the active-low bus-busy line, and on its low-to-high transition, which is the end of every bus cycle, it samples three active-low error inputs: memory protection, memory parity and external address. It samples them whether this processor or another master owned the cycle. Two side inputs, sampled at that same transition, tell the block which master owned the cycle and whether the cycle went to memory or to I/O. These two inputs choose the bit that the protection error and the address error land in.

The two system fault inputs are asynchronous. Each one passes through a synchronizer and a rising-edge detector, and only a new rising edge sets its bits. Software removes bits with a masked clear strobe. A fault that arrives in the same clock as a clear wins over the clear. A single any-fault output is high while any bit is set.

Bit numbering puts bit 0 at the most significant end: fault bit k appears on `fault_word[15-k]`.

Top module: `fltcap_top`

## Requirements
- R1: After a clock edge with `rst_n` low, `fault_word` is 0 and `any_fault` is low.
- R2: Fault bit k is driven on `fault_word[15-k]`. The bus error inputs are captured only at a clock edge where `busy_n` is high after being low at the previous edge. Error levels present while `busy_n` stays high, or while it stays low, change nothing.
- R3: At capture, a low `prot_err_n` sets bit 0 if `own_cycle` is 1 and bit 1 if `own_cycle` is 0, never both.
- R4: At capture, a low `par_err_n` sets bit 2, whatever the cycle context.
- R5: At capture, a low `addr_err_n` sets bit 5 if `mem_cycle` is 1 (memory) and bit 8 if `mem_cycle` is 0 (I/O), never both.
- R6: A rising edge on the asynchronous `sys_flt0` sets bit 7 at the third clock edge after the input rises, and not earlier. Holding the input high does not set the bit again after a clear.
- R7: A rising edge on `sys_flt1` sets both bit 13 and bit 15, with the same latency as R6.
- R8: Set bits stay set until a clock edge with `clr_we` high. That edge clears exactly the bits whose `clr_mask` position (same numbering as `fault_word`) is 1.
- R9: If a fault sets a bit at the same edge that a clear removes it, the bit ends up set.
- R10: `any_fault` is high exactly when `fault_word` is nonzero.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_n | input | 1 | Active-low bus busy; rising transition ends a cycle |
| own_cycle | input | 1 | 1 when this processor owns the current bus cycle |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| prot_err_n | input | 1 | Active-low memory protection error |
| par_err_n | input | 1 | Active-low memory parity error |
| addr_err_n | input | 1 | Active-low external address error |
| sys_flt0 | input | 1 | Asynchronous system fault, rising-edge active |
| sys_flt1 | input | 1 | Asynchronous system fault, rising-edge active |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 16 | Bits to clear, same numbering as fault_word |
| fault_word | output | 16 | Fault register, bit 0 at index 15 |
| any_fault | output | 1 | High when any fault bit is set |

## Verification
All 32 combinations of owner, memory/I/O and the three bus error levels are run through a complete bus cycle on an empty register. This separates the owner-selected protection bits from each other and the memory-selected address bits from each other, and shows that parity ignores context. Separate patterns hold the errors active without a busy rising edge, to show they are ignored, and then sweep single-bit clear masks across a full register. Further patterns make a fault coincide with a clear, step each system fault through its latency one clock at a time, and hold a system fault high across a clear, which shows the difference between edge sensitivity and level sensitivity.

// File: rtl/fltcap_pkg.sv
// Shared constants for the bus fault capture register.
// Assumes: fault bit 0 is the most significant bit of the word.
package fltcap_pkg;
    localparam int FW = 16;

    // Fault bit numbers (bit 0 = MSB of the word)
    localparam int unsigned B_PROT_OWN   = 0;
    localparam int unsigned B_PROT_OTHER = 1;
    localparam int unsigned B_PARITY     = 2;
    localparam int unsigned B_ADDR_MEM   = 5;
    localparam int unsigned B_SYS0       = 7;
    localparam int unsigned B_ADDR_IO    = 8;
    localparam int unsigned B_SYS1_LO    = 13;
    localparam int unsigned B_SYS1_HI    = 15;

    localparam int NUM_SYS = 2;

    // One-hot word for fault bit k
    function automatic logic [FW-1:0] bit_of(input int unsigned k);
        bit_of = FW'(1) << (FW - 1 - k);
    endfunction
endpackage

// File: rtl/fltcap_edge_sync.sv
// Synchronizes N asynchronous inputs through STAGES flops and emits a
// one-clock pulse on each synchronized rising edge.
// Assumes: inputs are quasi-static relative to clk (held for > 1 clock).
module fltcap_edge_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise_pulse
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the input through the synchronizer and remember the last value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[i]};
                prev  <= chain[LAST];
            end
        end

        assign rise_pulse[i] = chain[LAST] & ~prev;

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pulse[i] |=> !rise_pulse[i]); // R6
    end
endmodule

// File: rtl/fltcap_bus_sample.sv
// Detects the end of a bus cycle (busy_n low-to-high) and maps the
// active-low bus error inputs to fault bits based on cycle context.
// Assumes: busy_n and the context/error inputs are synchronous to clk.
module fltcap_bus_sample
    import fltcap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_n,
    input  logic          own_cycle,
    input  logic          mem_cycle,
    input  logic          prot_err_n,
    input  logic          par_err_n,
    input  logic          addr_err_n,
    output logic          cyc_end,
    output logic [FW-1:0] bus_set
);
    logic busy_q;

    // Hold busy_n from the previous edge; the bus idles high
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b1;
        else        busy_q <= busy_n;
    end

    assign cyc_end = busy_n & ~busy_q;

    // Route each active error to its context-dependent bit
    always_comb begin
        bus_set = '0;
        if (cyc_end) begin
            if (!prot_err_n) bus_set |= own_cycle ? bit_of(B_PROT_OWN) : bit_of(B_PROT_OTHER);
            if (!par_err_n)  bus_set |= bit_of(B_PARITY);
            if (!addr_err_n) bus_set |= mem_cycle ? bit_of(B_ADDR_MEM) : bit_of(B_ADDR_IO);
        end
    end

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> !cyc_end); // R2
endmodule

// File: rtl/fltcap_top.sv
// Sticky 16-bit fault register fed by bus-cycle error sampling and two
// asynchronous system fault lines; software clears bits with a mask.
// Assumes: synchronous active-low reset; a set beats a clear in one clock.
module fltcap_top
    import fltcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_n,
    input  logic          own_cycle,
    input  logic          mem_cycle,
    input  logic          prot_err_n,
    input  logic          par_err_n,
    input  logic          addr_err_n,
    input  logic          sys_flt0,
    input  logic          sys_flt1,
    input  logic          clr_we,
    input  logic [FW-1:0] clr_mask,
    output logic [FW-1:0] fault_word,
    output logic          any_fault
);
    localparam logic [FW-1:0] BUS_BITS = bit_of(B_PROT_OWN) | bit_of(B_PROT_OTHER)
                                       | bit_of(B_PARITY) | bit_of(B_ADDR_MEM)
                                       | bit_of(B_ADDR_IO);

    logic               cyc_end;
    logic [FW-1:0]      bus_set;
    logic [NUM_SYS-1:0] sys_rise;
    logic [FW-1:0]      sys_set;
    logic [FW-1:0]      set_all;
    logic [FW-1:0]      clr_bits;
    logic [FW-1:0]      fault_q;

    fltcap_bus_sample u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_n     (busy_n),
        .own_cycle  (own_cycle),
        .mem_cycle  (mem_cycle),
        .prot_err_n (prot_err_n),
        .par_err_n  (par_err_n),
        .addr_err_n (addr_err_n),
        .cyc_end    (cyc_end),
        .bus_set    (bus_set)
    );

    fltcap_edge_sync #(.N(NUM_SYS), .STAGES(SYNC_STAGES)) u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   ({sys_flt1, sys_flt0}),
        .rise_pulse (sys_rise)
    );

    // Map system fault edges to their bits
    always_comb begin
        sys_set = '0;
        if (sys_rise[0]) sys_set |= bit_of(B_SYS0);
        if (sys_rise[1]) sys_set |= bit_of(B_SYS1_LO) | bit_of(B_SYS1_HI);
    end

    assign set_all  = bus_set | sys_set;
    assign clr_bits = clr_we ? clr_mask : '0;

    // Sticky register: clear masked bits, then OR in new faults
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (fault_q & ~clr_bits) | set_all;
    end

    assign fault_word = fault_q;
    assign any_fault  = |fault_q;

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R8
    AST_BUS_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_q & ~$past(fault_q) & BUS_BITS) != '0) |-> $past(cyc_end)); // R2
    AST_PROT_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_q[FW-1-B_PROT_OWN] & ~$past(fault_q[FW-1-B_PROT_OWN]),
                  fault_q[FW-1-B_PROT_OTHER] & ~$past(fault_q[FW-1-B_PROT_OTHER])})); // R3
    AST_ADDR_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_q[FW-1-B_ADDR_MEM] & ~$past(fault_q[FW-1-B_ADDR_MEM]),
                  fault_q[FW-1-B_ADDR_IO] & ~$past(fault_q[FW-1-B_ADDR_IO])})); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((fault_q & $past(set_all)) == $past(set_all))); // R9
    AST_ANY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_fault) |-> $past(set_all != '0)); // R10
    AST_ANY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_fault) |-> $past(clr_we)); // R10
endmodule

// File: tb/fltcap_top_test.sv
module fltcap_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_n = 1'b1, own_cycle = 1'b0, mem_cycle = 1'b0;
    logic        prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
    logic        sys_flt0 = 1'b0, sys_flt1 = 1'b0;
    logic        clr_we = 1'b0;
    logic [15:0] clr_mask = '0;
    logic [15:0] fault_word;
    logic        any_fault;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fltcap_top uut (
        .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .own_cycle(own_cycle),
        .mem_cycle(mem_cycle), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
        .addr_err_n(addr_err_n), .sys_flt0(sys_flt0), .sys_flt1(sys_flt1),
        .clr_we(clr_we), .clr_mask(clr_mask), .fault_word(fault_word),
        .any_fault(any_fault)
    );

    function automatic logic [15:0] fb(input int k);
        return 16'h8000 >> k;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [15:0] exp);
        check(req, fault_word, exp);
        check({req, " any_fault"}, {15'd0, any_fault}, {15'd0, exp != 16'h0});
    endtask

    // Full bus cycle; faults presented on the closing edge
    task automatic bus_cycle(input logic own, input logic mem,
                             input logic prot, input logic par, input logic addr);
        @(negedge clk) busy_n = 1'b0;
        @(negedge clk);
        busy_n = 1'b1; own_cycle = own; mem_cycle = mem;
        prot_err_n = ~prot; par_err_n = ~par; addr_err_n = ~addr;
        @(negedge clk);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    endtask

    task automatic do_clear(input logic [15:0] m);
        @(negedge clk) clr_we = 1'b1; clr_mask = m;
        @(negedge clk) clr_we = 1'b0; clr_mask = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        check_word("R1 reset", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_word("R1 after release", 16'h0000);

        // R2: errors active with no busy rising edge are ignored
        prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
        repeat (4) @(negedge clk);
        check_word("R2 busy high steady", 16'h0000);
        busy_n = 1'b0;
        repeat (4) @(negedge clk);
        check_word("R2 busy low steady", 16'h0000);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        @(negedge clk) busy_n = 1'b1;
        @(negedge clk);
        check_word("R2 edge with no errors", 16'h0000);

        // R3 R4 R5: exhaustive context and error sweep
        for (int c = 0; c < 32; c++) begin
            do_clear(16'hFFFF);
            bus_cycle(c[4], c[3], c[2], c[1], c[0]);
            exp = 16'h0000;
            if (c[2]) exp |= c[4] ? fb(0) : fb(1);
            if (c[1]) exp |= fb(2);
            if (c[0]) exp |= c[3] ? fb(5) : fb(8);
            check_word($sformatf("R3 R4 R5 combo %0d", c), exp);
        end

        // R8: single-bit clear masks on a full register
        for (int k = 0; k < 16; k++) begin
            do_clear(16'hFFFF);
            bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            exp = fb(0) | fb(1) | fb(2) | fb(5) | fb(8);
            do_clear(fb(k));
            check_word($sformatf("R8 clear bit %0d", k), exp & ~fb(k));
        end
        repeat (5) @(negedge clk);
        check_word("R8 stays set", (fb(0) | fb(1) | fb(2) | fb(5) | fb(8)) & ~fb(15));

        // R9: fault coincides with a full clear
        do_clear(16'hFFFF);
        bus_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check_word("R9 setup", fb(2));
        @(negedge clk) busy_n = 1'b0;
        @(negedge clk);
        busy_n = 1'b1; own_cycle = 1'b1; prot_err_n = 1'b0;
        clr_we = 1'b1; clr_mask = 16'hFFFF;
        @(negedge clk);
        prot_err_n = 1'b1; clr_we = 1'b0; clr_mask = '0;
        check_word("R9 set beats clear", fb(0));

        // R6: system fault 0 latency and edge sensitivity
        do_clear(16'hFFFF);
        @(negedge clk) sys_flt0 = 1'b1;
        @(negedge clk);
        check_word("R6 after 1 edge", 16'h0000);
        @(negedge clk);
        check_word("R6 after 2 edges", 16'h0000);
        @(negedge clk);
        check_word("R6 after 3 edges", fb(7));
        do_clear(16'hFFFF);
        repeat (5) @(negedge clk);
        check_word("R6 held level no reset", 16'h0000);
        sys_flt0 = 1'b0;
        repeat (3) @(negedge clk);
        sys_flt0 = 1'b1;
        repeat (3) @(negedge clk);
        check_word("R6 second edge", fb(7));
        sys_flt0 = 1'b0;

        // R7: system fault 1 sets two bits
        do_clear(16'hFFFF);
        @(negedge clk) sys_flt1 = 1'b1;
        repeat (2) @(negedge clk);
        check_word("R7 before latency", 16'h0000);
        @(negedge clk);
        check_word("R7 both bits", fb(13) | fb(15));
        sys_flt1 = 1'b0;

        // R10: mixed sources then partial clears down to empty
        bus_cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check_word("R10 mixed", fb(1) | fb(5) | fb(13) | fb(15));
        do_clear(fb(13) | fb(15));
        check_word("R10 partial", fb(1) | fb(5));
        do_clear(fb(1) | fb(5));
        check_word("R10 empty", 16'h0000);

        // R1: reset after faults
        bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check_word("R1 reset clears", 16'h0000);
        rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule